// File: doc/BRIEF.md
# Dual-Clock FIFO with Width Conversion

This block is a first-in first-out buffer with a write port and a read port on unrelated clocks. The two ports may have different data widths, provided the wider one is a power-of-two multiple of the narrower one. Any width is accepted, so side bits such as parity simply travel with the data. Storage is a dual-port array of narrow units. Each side keeps its own pointer, counted in its own word size, and passes it to the other side as a Gray code through a two-flop synchronizer.

Each side reports its own occupancy in its own word units. From that count it derives full or empty, a programmable-level flag and a one-cycle error pulse for a refused request. When the write port is narrower, the sub-words are packed least significant first. When the read port is narrower, each write word is handed out least significant part first. A parameter selects first-word-fall-through reads, where the oldest word is shown on the read data output before any read enable. One reset input clears both sides. It is applied asynchronously and released on each clock separately.

Top module: `async_width_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with every bit intact, side bits included.
- R2: When the write port is narrower, the first accepted write word occupies the least significant bits of a read word.
- R3: When the read port is narrower, the least significant read-width slice of a write word is read first.
- R4: `wr_count` gives occupancy in write words, and `full` is high exactly when it equals the write-side depth. A write word that has been read only in part still counts as occupied.
- R5: `rd_count` gives occupancy in complete read words, and `empty` is high exactly when it is zero. A read word that has been written only in part is not visible.
- R6: A write request while `full` is high is dropped and raises `wr_err` for the next write clock only.
- R7: A read request while `empty` is high raises `rd_err` for the next read clock only, and the read data does not change.
- R8: `prog_full` is high when `wr_count` is at or above the PF_TH parameter.
- R9: `prog_empty` is high when `rd_count` is at or below the PE_TH parameter.
- R10: With FWFT set, the oldest complete read word appears on `rd_data` without a read enable, and `rd_en` removes it.
- R11: After reset both counts are zero, `empty` and `prog_empty` are high, and `full`, `prog_full`, `wr_err` and `rd_err` are low.
- R12: A change made on one side reaches the other side's count within a few cycles of that side's clock. Until then the count errs toward full on the write side and toward empty on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| full | output | 1 | Write side is full |
| prog_full | output | 1 | Write occupancy at or above PF_TH |
| wr_err | output | 1 | Refused write, one-cycle pulse |
| wr_count | output | WCW | Occupancy in write words |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Read word |
| empty | output | 1 | No complete read word stored |
| prog_empty | output | 1 | Read occupancy at or below PE_TH |
| rd_err | output | 1 | Refused read, one-cycle pulse |
| rd_count | output | RCW | Occupancy in read words |

## Verification
A corrupted read pointer or a wrong unpacking order shows up at the next read as a slice that is out of sequence. A mistake in the Gray code or in the synchronizer shows up as a count on the far side that is wrong by more than the words in flight, a few clocks after the change. A write pointer that advances past a refused write makes the read side return a word that was never accepted. An error in the partial-word rounding appears as `full` falling, or `empty` clearing, one word too early at a ratio boundary. Directed steps at those boundaries are mixed with a long random run that is checked against a queue model.

// File: rtl/async_width_fifo.sv
`timescale 1ns/1ps
module async_width_fifo #(
  parameter int WR_W = 36,
  parameter int RD_W = 9,
  parameter int DEPTH_U = 32,
  parameter int PF_TH = 6,
  parameter int PE_TH = 4,
  parameter bit FWFT = 1'b0,
  localparam int UW = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int WR_U = WR_W / UW,
  localparam int RD_U = RD_W / UW,
  localparam int LG_W = $clog2(WR_U),
  localparam int LG_R = $clog2(RD_U),
  localparam int UA = $clog2(DEPTH_U) + 1,
  localparam int AU = UA - 1,
  localparam int WCW = UA - LG_W,
  localparam int RCW = UA - LG_R,
  localparam int WR_DEPTH = DEPTH_U / WR_U,
  localparam int RD_DEPTH = DEPTH_U / RD_U
) (
  input  logic            rst,
  input  logic            wclk,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic            full,
  output logic            prog_full,
  output logic            wr_err,
  output logic [WCW-1:0]  wr_count,
  input  logic            rclk,
  input  logic            rd_en,
  output logic [RD_W-1:0] rd_data,
  output logic            empty,
  output logic            prog_empty,
  output logic            rd_err,
  output logic [RCW-1:0]  rd_count
);

  function automatic logic [UA-1:0] g2b(input logic [UA-1:0] g);
    logic [UA-1:0] b;
    b[UA-1] = g[UA-1];
    for (int i = UA - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0] wrs, rrs;
  logic wrst, rrst;

  always_ff @(posedge wclk or posedge rst)
    if (rst) wrs <= 2'b11;
    else     wrs <= {wrs[0], 1'b0};

  always_ff @(posedge rclk or posedge rst)
    if (rst) rrs <= 2'b11;
    else     rrs <= {rrs[0], 1'b0};

  assign wrst = wrs[1];
  assign rrst = rrs[1];

  logic [UW-1:0] mem [DEPTH_U];

  // write side
  logic [WCW-1:0] wptr, wptr_nx, wgray;
  logic [RCW-1:0] rg_w1, rg_w2;
  logic           wr_ok;
  logic [AU-1:0]  wbase;

  assign wr_count  = wptr - WCW'((g2b(UA'(rg_w2)) << LG_R) >> LG_W);
  assign full      = (wr_count == WCW'(WR_DEPTH));
  assign prog_full = (wr_count >= WCW'(PF_TH));
  assign wr_ok     = wr_en && !full && !wrst;
  assign wptr_nx   = wptr + WCW'(wr_ok);
  assign wbase     = AU'(UA'(wptr) << LG_W);

  always_ff @(posedge wclk or posedge wrst)
    if (wrst) begin
      wptr <= '0; wgray <= '0; rg_w1 <= '0; rg_w2 <= '0; wr_err <= 1'b0;
    end else begin
      wptr   <= wptr_nx;
      wgray  <= wptr_nx ^ (wptr_nx >> 1);
      rg_w1  <= rgray;
      rg_w2  <= rg_w1;
      wr_err <= wr_en && full;
    end

  always_ff @(posedge wclk)
    if (wr_ok)
      for (int i = 0; i < WR_U; i++) mem[wbase + AU'(i)] <= wr_data[i*UW +: UW];

  // read side
  logic [RCW-1:0]  rptr, rptr_nx, rgray;
  logic [WCW-1:0]  wg_r1, wg_r2;
  logic            rd_ok;
  logic [AU-1:0]   rbase;
  logic [RD_W-1:0] head, rd_q;

  assign rd_count   = RCW'((g2b(UA'(wg_r2)) << LG_W) >> LG_R) - rptr;
  assign empty      = (rd_count == '0);
  assign prog_empty = (rd_count <= RCW'(PE_TH));
  assign rd_ok      = rd_en && !empty && !rrst;
  assign rptr_nx    = rptr + RCW'(rd_ok);
  assign rbase      = AU'(UA'(rptr) << LG_R);

  always_comb
    for (int i = 0; i < RD_U; i++) head[i*UW +: UW] = mem[rbase + AU'(i)];

  always_ff @(posedge rclk or posedge rrst)
    if (rrst) begin
      rptr <= '0; rgray <= '0; wg_r1 <= '0; wg_r2 <= '0; rd_err <= 1'b0; rd_q <= '0;
    end else begin
      rptr   <= rptr_nx;
      rgray  <= rptr_nx ^ (rptr_nx >> 1);
      wg_r1  <= wgray;
      wg_r2  <= wg_r1;
      rd_err <= rd_en && empty;
      if (rd_ok) rd_q <= head;
    end

  assign rd_data = FWFT ? head : rd_q;

  p_wcount_bound_r4: assert property (@(posedge wclk) disable iff (wrst)
    wr_count <= WCW'(WR_DEPTH));
  p_rcount_bound_r5: assert property (@(posedge rclk) disable iff (rrst)
    rd_count <= RCW'(RD_DEPTH));
  p_drop_on_full_r6: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> (wr_count <= $past(wr_count)));
  p_err_after_full_r6: assert property (@(posedge wclk) disable iff (wrst)
    wr_err |-> $past(full));
  p_hold_on_rderr_r7: assert property (@(posedge rclk) disable iff (rrst || FWFT)
    rd_err |-> $stable(rd_data));
  p_full_in_pfull_r8: assert property (@(posedge wclk) disable iff (wrst)
    full |-> prog_full);
  p_empty_in_pempty_r9: assert property (@(posedge rclk) disable iff (rrst)
    empty |-> prog_empty);

endmodule

// File: tb/async_width_fifo_tb.sv
`timescale 1ns/1ps
module async_width_fifo_tb_top;
  logic rst = 1'b1, wclk = 1'b0, rclk = 1'b0;
  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  logic        wr_en = 0, rd_en = 0;
  logic [35:0] wr_data = '0;
  logic [8:0]  rd_data;
  logic        full, prog_full, wr_err, empty, prog_empty, rd_err;
  logic [3:0]  wr_count;
  logic [5:0]  rd_count;

  async_width_fifo #(.WR_W(36), .RD_W(9), .DEPTH_U(32), .PF_TH(6), .PE_TH(4), .FWFT(1'b0)) dut_i (
    .rst(rst), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .prog_full(prog_full), .wr_err(wr_err), .wr_count(wr_count),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .prog_empty(prog_empty), .rd_err(rd_err), .rd_count(rd_count));

  logic        w2_en = 0, r2_en = 0;
  logic [7:0]  w2_data = '0;
  logic [31:0] r2_data;
  logic        f2, pf2, we2, e2, pe2, re2;
  logic [4:0]  wc2;
  logic [2:0]  rc2;

  async_width_fifo #(.WR_W(8), .RD_W(32), .DEPTH_U(16), .PF_TH(12), .PE_TH(1), .FWFT(1'b1)) dut_pk_i (
    .rst(rst), .wclk(wclk), .wr_en(w2_en), .wr_data(w2_data), .full(f2),
    .prog_full(pf2), .wr_err(we2), .wr_count(wc2),
    .rclk(rclk), .rd_en(r2_en), .rd_data(r2_data), .empty(e2),
    .prog_empty(pe2), .rd_err(re2), .rd_count(rc2));

  int checks = 0, failures = 0;
  logic [8:0] q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [35:0] d);
    @(negedge wclk);
    wr_en = 1; wr_data = d;
    if (!full) for (int i = 0; i < 4; i++) q.push_back(d[i*9 +: 9]);
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic rd_unit(input string tag);
    logic [8:0] e;
    @(negedge rclk);
    rd_en = 1;
    e = (q.size() > 0) ? q.pop_front() : 9'h0;
    @(negedge rclk);
    rd_en = 0;
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic settle();
    #100;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] hold;
    void'($urandom(32'd20240611));
    #40 rst = 0;
    #60;
    // R11 reset state
    chk(empty && prog_empty && !full && !prog_full && !wr_err && !rd_err, "R11 flags",
        {full, prog_full, empty, prog_empty}, 4'b0011);
    chk(wr_count == 0 && rd_count == 0, "R11 counts", {wr_count, rd_count}, 0);

    for (int k = 0; k < 8; k++) begin
      wr_word({4'h0, 32'hA0B1C2D3} ^ (36'h123456789 * (k + 1)));
      if (k == 4) chk(!prog_full, "R8 below threshold", prog_full, 0);
      if (k == 5) chk(prog_full, "R8 at threshold", prog_full, 1);
    end
    chk(full && wr_count == 8, "R4 full at depth", {full, wr_count}, {1'b1, 4'd8});

    wr_word(36'hFFFFFFFFF);
    chk(wr_err, "R6 error pulse", wr_err, 1);
    @(negedge wclk);
    chk(!wr_err, "R6 pulse one cycle", wr_err, 0);
    chk(wr_count == 8, "R6 write dropped", wr_count, 8);

    settle();
    chk(!empty && rd_count == 32, "R12 read count after sync", rd_count, 32);

    rd_unit("R3 first slice is least significant");
    chk(rd_count == 31, "R5 count after one read", rd_count, 31);
    settle();
    chk(full && wr_count == 8, "R4 partial word still occupied", {full, wr_count}, {1'b1, 4'd8});
    for (int k = 0; k < 3; k++) rd_unit("R3 slice order");
    settle();
    chk(!full && wr_count == 7, "R4 word freed", {full, wr_count}, {1'b0, 4'd7});

    while (rd_count > 5) rd_unit("R1 drain order");
    chk(!prog_empty, "R9 above threshold", prog_empty, 0);
    rd_unit("R1 drain order");
    chk(prog_empty, "R9 at threshold", prog_empty, 1);
    while (rd_count > 0) rd_unit("R1 drain order");
    chk(empty, "R5 empty after drain", empty, 1);

    hold = rd_data;
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk(rd_err, "R7 error pulse", rd_err, 1);
    chk(rd_data == hold, "R7 data held", rd_data, hold);
    @(negedge rclk);
    chk(!rd_err, "R7 pulse one cycle", rd_err, 0);

    // random traffic
    fork
      begin
        for (int n = 0; n < 2000; n++) begin
          logic [35:0] d;
          @(negedge wclk);
          d = {$urandom, $urandom};
          wr_en = ($urandom % 4) != 0;
          wr_data = d;
          if (wr_en && !full) for (int i = 0; i < 4; i++) q.push_back(d[i*9 +: 9]);
        end
        @(negedge wclk); wr_en = 0;
      end
      begin
        bit pend = 0;
        logic [8:0] e = '0;
        for (int n = 0; n < 2000; n++) begin
          @(negedge rclk);
          if (pend) chk(rd_data == e, "R1 random order", rd_data, e);
          pend = 0;
          rd_en = $urandom % 2;
          if (rd_en && !empty) begin
            if (q.size() == 0) chk(0, "R12 read side ahead of writes", 1, 0);
            else begin e = q.pop_front(); pend = 1; end
          end
        end
        @(negedge rclk);
        rd_en = 0;
        if (pend) chk(rd_data == e, "R1 random order", rd_data, e);
      end
    join
    settle();
    while (!empty) rd_unit("R1 final drain");
    chk(q.size() == 0, "R1 nothing lost", q.size(), 0);

    // narrow write, wide read, fall-through
    for (int k = 0; k < 3; k++) begin
      @(negedge wclk); w2_en = 1; w2_data = 8'hA1 + 8'h11 * k;
      @(negedge wclk); w2_en = 0;
    end
    settle();
    chk(e2 && rc2 == 0, "R5 partial read word hidden", {e2, rc2}, {1'b1, 3'd0});
    @(negedge wclk); w2_en = 1; w2_data = 8'hD4;
    @(negedge wclk); w2_en = 0;
    settle();
    chk(!e2 && rc2 == 1, "R5 complete read word visible", {e2, rc2}, {1'b0, 3'd1});
    chk(r2_data == 32'hD4C3B2A1, "R2 R10 packed head without read", r2_data, 32'hD4C3B2A1);
    @(negedge rclk); r2_en = 1;
    @(negedge rclk); r2_en = 0;
    chk(e2, "R10 read enable removes head", e2, 1);
    settle();
    chk(wc2 == 0, "R12 write count after sync", wc2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule